// File: doc/BRIEF.md
# River Perspective Slope Sequencer

This block works out, once per scanline, where a scrolling river texture starts and how strongly it is stretched, and then walks a tile column and tile row across the 256 pixels of the line. When a line begins, a fixed 32-word control program runs. It takes one word per clock. The program reads 4-bit slope values from an external slope ROM and combines them with values held in a 64-nibble scratch RAM. It does this through a 4-bit adder with a carry. The results move through a short pre-adder chain and a 10-stage nibble chain. Some of the results are written back to the RAM, so the curve of the river builds up from one line to the next.

When the program has finished, the nibble chain supplies four things: the tile row, the first tile column, the start value of a horizontal stretch counter, and its reload value. A pixel stage then produces one tile address per clock, with a valid strobe. For each pixel it advances the stretch counter by several ticks, and the column steps on every counter overflow. The slope ROM and the scratch RAM are external and are read asynchronously. Tile pixel decode and collision are handled elsewhere.

Top module: `river_slope_engine`

## Requirements
- R1: A `line_start` pulse sampled while the sequencer is idle starts a run of exactly 32 control words, one per clock, in the fixed program order 0D 0F 4D 2F CD 0F 4D 2F C5 0D 6D EE 0D 6D EE 0D 6D EE 8D 4D 01 69 EA 09 69 EA 19 69 EA 09 69 EA. Exactly 256 pixel cycles follow the run.
- R2: Two 4-bit counters, a RAM counter and a ROM counter, start at zero on every line. The RAM counter advances when bit 7 of the previous word was 1. The ROM counter advances when bit 6 changes from 0 in the previous word to 1 in the current word.
- R3: The slope ROM address is {bank[1:0], line counter[6:1], ROM counter[3:1]}. The ROM nibble used is data[7:4] when ROM counter bit 0 is 1, and data[3:0] otherwise.
- R4: The scratch RAM address is {A5, RAM counter[3:0], word bit 5}. A5 is 0 only when word bit 0, word bit 6 and the preload flag are all 1, and the preload flag is set for line numbers below 32. All writes therefore land in the upper half of the RAM.
- R5: Words 01, 09, 19, 0D and 8D load the ROM nibble into the first pre-adder stage. Words 4D, 69, 6D, C5 and CD load the RAM nibble into that stage. Words 0F and 2F write the ROM nibble to the RAM and to the chain. Words EA and EE write to the RAM and to the chain: pre[1] when line counter bit 0 is 1, and otherwise the low nibble of pre[1]+pre[2]+carry.
- R6: A word with bit 1 set shifts the 10-stage chain, and a word with bit 1 clear shifts the pre-adder chain. After a word with bit 1 set, the carry takes the carry-out of pre[1]+pre[2]+carry. A word with bit 3 clear forces the carry to 0.
- R7: The line counter loads the horizon value on line 30 and then adds one on every line, wrapping at 8 bits. No pixel is marked valid on a line whose counter has bit 7 set.
- R8: After a word with bit 4 set, an 8-bit start value {stage 8, stage 9} is captured. The stretch counter begins at 0x80 | start>>1. On a tick where the counter is above 0xFF, it reloads to {1, stage 8, stage 9[3:1]} and the column increments. The reloaded counter is reduced by one when stage 9 bit 0 and the new column bit 0 are both 1. On any other tick the counter adds one.
- R9: Pixels 0 to 15 each take 2 counter ticks, and pixels 16 to 255 each take 4 ticks. The ticks are applied before the pixel is emitted.
- R10: Each valid pixel presents the column (low 9 bits, starting as {stage 5 bit 0, stage 6, stage 7}) and the row {stage 1[2:0], stage 2, stage 3[3:2]}. The row stays constant across the line, and the column never advances by more than one between neighbouring pixels.
- R11: During and after reset, `pix_valid` and `ram_we` are low, and the line counter restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Begin processing of a scanline |
| line_num | input | 9 | Number of the line being started |
| horizon | input | 8 | Line-counter load value used on line 30 |
| slope_bank | input | 2 | Upper slope ROM address bits |
| rom_addr | output | 11 | Slope ROM address |
| rom_data | input | 8 | Slope ROM byte (asynchronous read) |
| ram_addr | output | 6 | Scratch RAM address |
| ram_we | output | 1 | Scratch RAM write enable |
| ram_wdata | output | 4 | Scratch RAM write nibble |
| ram_rdata | input | 4 | Scratch RAM read nibble (asynchronous read) |
| pix_valid | output | 1 | Tile address valid for this pixel |
| tile_col | output | 9 | Tile column of the pixel |
| tile_row | output | 9 | Tile row of the line |

## Verification
The lines run in the bench vary the line number and the bank. They cover preload lines, where RAM reads come from the lower half, and later lines, where they come from the upper half. They also drive horizon values that carry the line counter into the bit-7 suppression region and through its 8-bit wrap, which tells the load-on-line-30 rule apart from plain counting. The scratch RAM keeps its contents from line to line, so a wrong adder, carry or write-select choice shows up both in the RAM image and in the column and row trace of later lines. Finally, a reset in the middle of the pixel phase checks that output stops and that the line counter restarts.

// File: rtl/river_pkg.sv
package river_pkg;

    localparam int NIB_W   = 4;
    localparam int STEPS   = 32;
    localparam int STEP_W  = $clog2(STEPS);
    localparam int TRAIN_N = 10;
    localparam int PRE_N   = 3;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [TRAIN_N-1:0][NIB_W-1:0] train_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ROM_PRE,
        OP_ROM_WR,
        OP_RAM_PRE,
        OP_SUM_WR
    } op_e;

    // fixed microprogram; order is behaviour
    function automatic logic [7:0] ctrl_word(input logic [STEP_W-1:0] s);
        logic [7:0] w;
        case (s)
            5'd0:  w = 8'h0D;  5'd1:  w = 8'h0F;  5'd2:  w = 8'h4D;  5'd3:  w = 8'h2F;
            5'd4:  w = 8'hCD;  5'd5:  w = 8'h0F;  5'd6:  w = 8'h4D;  5'd7:  w = 8'h2F;
            5'd8:  w = 8'hC5;  5'd9:  w = 8'h0D;  5'd10: w = 8'h6D;  5'd11: w = 8'hEE;
            5'd12: w = 8'h0D;  5'd13: w = 8'h6D;  5'd14: w = 8'hEE;  5'd15: w = 8'h0D;
            5'd16: w = 8'h6D;  5'd17: w = 8'hEE;  5'd18: w = 8'h8D;  5'd19: w = 8'h4D;
            5'd20: w = 8'h01;  5'd21: w = 8'h69;  5'd22: w = 8'hEA;  5'd23: w = 8'h09;
            5'd24: w = 8'h69;  5'd25: w = 8'hEA;  5'd26: w = 8'h19;  5'd27: w = 8'h69;
            5'd28: w = 8'hEA;  5'd29: w = 8'h09;  5'd30: w = 8'h69;  5'd31: w = 8'hEA;
            default: w = 8'h00;
        endcase
        return w;
    endfunction

    function automatic op_e decode_op(input logic [7:0] w);
        case (w)
            8'h01, 8'h09, 8'h19, 8'h0D, 8'h8D: return OP_ROM_PRE;
            8'h0F, 8'h2F:                      return OP_ROM_WR;
            8'h4D, 8'h69, 8'h6D, 8'hC5, 8'hCD: return OP_RAM_PRE;
            8'hEA, 8'hEE:                      return OP_SUM_WR;
            default:                           return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/river_seq.sv
module river_seq
    import river_pkg::*;
#(
    parameter int BANK_W        = 2,
    parameter int LINE_W        = 9,
    parameter int LOAD_LINE     = 30,
    parameter int PRELOAD_LINES = 32,
    localparam int ROM_AW       = BANK_W + 6 + 3,
    localparam int RAM_AW       = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LINE_W-1:0]  line_num,
    input  logic [7:0]         horizon,
    input  logic [BANK_W-1:0]  bank,
    output logic [ROM_AW-1:0]  rom_addr,
    input  logic [7:0]         rom_data,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic               ram_we,
    output logic [NIB_W-1:0]   ram_wdata,
    input  logic [NIB_W-1:0]   ram_rdata,
    output logic               done,
    output train_t             train,
    output logic [7:0]         hosc,
    output logic [7:0]         vline
);

    typedef struct packed {
        logic                        busy;
        logic                        done;
        logic [STEP_W-1:0]           step;
        logic [7:0]                  prev;
        logic [3:0]                  ramc;
        logic [3:0]                  romc;
        logic                        carry;
        logic [7:0]                  hosc;
        logic [PRE_N-1:0][NIB_W-1:0] pre;
        train_t                      tr;
        logic [7:0]                  vline;
        logic                        preload;
        logic [BANK_W-1:0]           bank;
    } seq_s;

    seq_s q, d;

    logic [7:0] w;
    op_e        op;
    logic [3:0] ramc_e, romc_e;
    logic [4:0] sum5;
    logic       carry_e;
    nib_t       sum_e, rom_nib, p0n, t0n;
    logic       a5;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        w       = ctrl_word(q.step);
        op      = decode_op(w);

        // counter values seen by the current word
        ramc_e  = q.prev[7] ? q.ramc + 4'd1 : q.ramc;
        romc_e  = (w[6] && !q.prev[6]) ? q.romc + 4'd1 : q.romc;
        sum5    = {1'b0, q.pre[1]} + {1'b0, q.pre[2]} + {4'b0, q.carry};
        carry_e = q.prev[1] ? sum5[4] : q.carry;
        if (!w[3]) carry_e = 1'b0;
        sum_e   = q.pre[1] + q.pre[2] + {3'b0, carry_e};

        rom_addr = {q.bank, q.vline[6:1], romc_e[3:1]};
        rom_nib  = romc_e[0] ? rom_data[7:4] : rom_data[3:0];
        a5       = ~(w[0] & w[6] & q.preload);
        ram_addr = {a5, ramc_e, w[5]};

        ram_wdata = (op == OP_ROM_WR) ? rom_nib : (q.vline[0] ? q.pre[1] : sum_e);
        ram_we    = q.busy && (op == OP_ROM_WR || op == OP_SUM_WR);

        p0n = q.pre[0];
        if (op == OP_ROM_PRE) p0n = rom_nib;
        if (op == OP_RAM_PRE) p0n = ram_rdata;
        t0n = (op == OP_ROM_WR || op == OP_SUM_WR) ? ram_wdata : q.tr[0];

        if (q.busy) begin
            d.step  = q.step + 1'b1;
            d.prev  = w;
            d.ramc  = ramc_e;
            d.romc  = romc_e;
            d.carry = carry_e;
            d.hosc  = q.prev[4] ? {q.tr[8], q.tr[9]} : q.hosc;
            if (w[1]) begin
                d.tr = {q.tr[8:1], t0n, t0n};
            end else begin
                d.pre = {q.pre[1], p0n, p0n};
            end
            if (q.step == STEP_W'(STEPS - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end else if (start) begin
            d.busy    = 1'b1;
            d.step    = '0;
            d.prev    = '0;
            d.ramc    = '0;
            d.romc    = '0;
            d.carry   = 1'b0;
            d.hosc    = '0;
            d.pre     = '0;
            d.tr      = '0;
            d.vline   = ((line_num == LINE_W'(LOAD_LINE)) ? horizon : q.vline) + 8'd1;
            d.preload = (line_num < LINE_W'(PRELOAD_LINES));
            d.bank    = bank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done  = q.done;
    assign train = q.tr;
    assign hosc  = q.hosc;
    assign vline = q.vline;

    a_r1_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.step != STEP_W'(STEPS - 1)) |=> (q.busy && q.step == $past(q.step) + 1'b1));
    a_r1_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.step == STEP_W'(STEPS - 1)) |=> (!q.busy && q.done));
    a_r4_write_upper: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_addr[RAM_AW-1]);
    a_r5_write_words: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (w == 8'h0F || w == 8'h2F || w == 8'hEA || w == 8'hEE));

endmodule

// File: rtl/river_stretch.sv
module river_stretch
    import river_pkg::*;
#(
    parameter int PIXELS      = 256,
    parameter int FIRST_PIX   = 16,
    parameter int TICKS_FIRST = 2,
    parameter int TICKS_REST  = 4,
    parameter int COL_W       = 12,
    parameter int OUT_W       = 9,
    localparam int PIX_W      = $clog2(PIXELS),
    localparam int MAX_TICKS  = (TICKS_FIRST > TICKS_REST) ? TICKS_FIRST : TICKS_REST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       hosc,
    input  train_t           tr,
    input  logic             suppress,
    output logic             pix_valid,
    output logic [OUT_W-1:0] tile_col,
    output logic [OUT_W-1:0] tile_row
);

    typedef struct packed {
        logic             active;
        logic             supp;
        logic [PIX_W-1:0] pix;
        logic [8:0]       h;
        logic [COL_W-1:0] col;
        logic [7:0]       rl;
        logic             skip;
        logic [OUT_W-1:0] row;
        logic             valid;
        logic [OUT_W-1:0] ocol;
        logic [OUT_W-1:0] orow;
    } str_s;

    str_s q, d;

    logic [8:0]       hv;
    logic [COL_W-1:0] cv;
    int               nt;

    wire unused_bits = ^{tr[0], tr[4], tr[1][3], tr[3][1:0], tr[5][3:1], hosc[0]};

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        hv      = q.h;
        cv      = q.col;
        nt      = (q.pix < PIX_W'(FIRST_PIX)) ? TICKS_FIRST : TICKS_REST;
        for (int k = 0; k < MAX_TICKS; k++) begin
            if (k < nt) begin
                if (hv[8]) begin
                    hv = {1'b0, q.rl};
                    cv = cv + 1'b1;
                    if (q.skip && cv[0]) hv = hv - 1'b1;
                end else begin
                    hv = hv + 1'b1;
                end
            end
        end

        if (q.active) begin
            d.h     = hv;
            d.col   = cv;
            d.valid = !q.supp;
            d.ocol  = cv[OUT_W-1:0];
            d.orow  = q.row;
            d.pix   = q.pix + 1'b1;
            if (q.pix == PIX_W'(PIXELS - 1)) d.active = 1'b0;
        end

        if (load) begin
            d.active = 1'b1;
            d.supp   = suppress;
            d.pix    = '0;
            d.h      = {2'b01, hosc[7:1]};
            d.col    = {{(COL_W-9){1'b0}}, tr[5][0], tr[6], tr[7]};
            d.rl     = {1'b1, tr[8], tr[9][3:1]};
            d.skip   = tr[9][0];
            d.row    = {tr[1][2:0], tr[2], tr[3][3:2]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pix_valid = q.valid;
    assign tile_col  = q.ocol;
    assign tile_row  = q.orow;

    a_r10_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && $past(q.valid)) |-> (q.ocol == $past(q.ocol) || q.ocol == $past(q.ocol) + 1'b1));
    a_r10_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && $past(q.valid)) |-> (q.orow == $past(q.orow)));
    a_r7_no_valid_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.supp) |=> !q.valid);

endmodule

// File: rtl/river_slope_engine.sv
module river_slope_engine
    import river_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int LINE_W = 9,
    parameter int OUT_W  = 9,
    localparam int ROM_AW = BANK_W + 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic [7:0]        horizon,
    input  logic [BANK_W-1:0] slope_bank,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    output logic [5:0]        ram_addr,
    output logic              ram_we,
    output logic [3:0]        ram_wdata,
    input  logic [3:0]        ram_rdata,
    output logic              pix_valid,
    output logic [OUT_W-1:0]  tile_col,
    output logic [OUT_W-1:0]  tile_row
);

    logic       seq_done;
    train_t     seq_train;
    logic [7:0] seq_hosc;
    logic [7:0] seq_vline;

    river_seq #(.BANK_W(BANK_W), .LINE_W(LINE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (line_start),
        .line_num  (line_num),
        .horizon   (horizon),
        .bank      (slope_bank),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .done      (seq_done),
        .train     (seq_train),
        .hosc      (seq_hosc),
        .vline     (seq_vline)
    );

    wire unused_vline = ^seq_vline[6:0];

    river_stretch #(.OUT_W(OUT_W)) u_str (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (seq_done),
        .hosc      (seq_hosc),
        .tr        (seq_train),
        .suppress  (seq_vline[7]),
        .pix_valid (pix_valid),
        .tile_col  (tile_col),
        .tile_row  (tile_row)
    );

endmodule

// File: tb/test_river_slope_engine.sv
module test_river_slope_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    localparam int LINE_WAIT = 300;

    // {line[8:0], horizon[7:0], bank[1:0], expect_pixels}
    localparam logic [19:0] VEC [NVEC] = '{
        {9'd30,  8'h10, 2'd0, 1'b1},
        {9'd31,  8'h00, 2'd0, 1'b1},
        {9'd40,  8'h00, 2'd1, 1'b1},
        {9'd41,  8'h00, 2'd1, 1'b1},
        {9'd30,  8'h7E, 2'd2, 1'b1},
        {9'd31,  8'h00, 2'd2, 1'b0},
        {9'd32,  8'h00, 2'd2, 1'b0},
        {9'd30,  8'hFE, 2'd3, 1'b0},
        {9'd31,  8'h00, 2'd3, 1'b1},
        {9'd50,  8'h00, 2'd3, 1'b1},
        {9'd100, 8'h00, 2'd0, 1'b1},
        {9'd200, 8'h00, 2'd2, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [8:0]  line_num = '0;
    logic [7:0]  horizon = '0;
    logic [1:0]  slope_bank = '0;
    logic [10:0] rom_addr;
    logic [7:0]  rom_data;
    logic [5:0]  ram_addr;
    logic        ram_we;
    logic [3:0]  ram_wdata;
    logic [3:0]  ram_rdata;
    logic        pix_valid;
    logic [8:0]  tile_col;
    logic [8:0]  tile_row;

    logic [3:0] sram [64];
    logic [3:0] mref [64];
    int got_col [256];
    int got_row [256];
    int got_n = 0;
    int exp_col [256];
    int exp_row;
    int exp_n;
    int mv = 0;
    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    function automatic logic [7:0] rom_byte(input int a);
        return 8'((a * 29) ^ (a >> 3) ^ 53);
    endfunction

    function automatic int word_of(input int i);
        case (i)
            0: return 'h0D;  1: return 'h0F;  2: return 'h4D;  3: return 'h2F;
            4: return 'hCD;  5: return 'h0F;  6: return 'h4D;  7: return 'h2F;
            8: return 'hC5;  9: return 'h0D; 10: return 'h6D; 11: return 'hEE;
           12: return 'h0D; 13: return 'h6D; 14: return 'hEE; 15: return 'h0D;
           16: return 'h6D; 17: return 'hEE; 18: return 'h8D; 19: return 'h4D;
           20: return 'h01; 21: return 'h69; 22: return 'hEA; 23: return 'h09;
           24: return 'h69; 25: return 'hEA; 26: return 'h19; 27: return 'h69;
           28: return 'hEA; 29: return 'h09; 30: return 'h69; 31: return 'hEA;
           default: return 0;
        endcase
    endfunction

    assign rom_data  = rom_byte(int'(rom_addr));
    assign ram_rdata = sram[ram_addr];

    always @(posedge clk) if (ram_we) sram[ram_addr] <= ram_wdata;

    river_slope_engine i_river_slope_engine (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
        .horizon(horizon), .slope_bank(slope_bank), .rom_addr(rom_addr),
        .rom_data(rom_data), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .pix_valid(pix_valid),
        .tile_col(tile_col), .tile_row(tile_row)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && pix_valid) begin
            got_col[got_n & 255] = int'(tile_col);
            got_row[got_n & 255] = int'(tile_row);
            got_n++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            failures++;
            $display("FAIL R1 watchdog expired actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model of one line, written from the requirements
    task automatic run_model(input int line, input int hz, input int bk);
        int pre[3] = '{0, 0, 0};
        int tr[10] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        int st, nib, a5, ra, ro, v, h, th;
        int ps = 0, rc = 0, oc = 0, hosc = 0, cy = 0;
        bit pl;
        if (line == 30) mv = hz;
        mv = (mv + 1) & 255;
        pl = (line < 32);
        for (int i = 0; i < 32; i++) begin
            st = word_of(i);
            if ((ps & 'h80) != 0) rc = (rc + 1) & 15;
            if ((st & 'h40) != 0 && (ps & 'h40) == 0) oc = (oc + 1) & 15;
            if ((ps & 2) != 0) cy = ((pre[1] + pre[2] + cy) > 15) ? 1 : 0;
            if ((st & 8) == 0) cy = 0;
            if ((ps & 'h10) != 0) hosc = (tr[8] << 4) | tr[9];
            ro  = (bk << 9) | ((mv & 'h7E) << 2) | ((oc & 14) >> 1);
            nib = ((oc & 1) != 0) ? (int'(rom_byte(ro)) >> 4) & 15 : int'(rom_byte(ro)) & 15;
            a5  = ((st & 1) != 0 && (st & 'h40) != 0 && pl) ? 0 : 1;
            ra  = (a5 << 5) | (rc << 1) | ((st >> 5) & 1);
            case (st)
                'h01, 'h09, 'h19, 'h0D, 'h8D: pre[0] = nib;
                'h0F, 'h2F: begin tr[0] = nib; mref[ra] = 4'(nib); end
                'h4D, 'h69, 'h6D, 'hC5, 'hCD: pre[0] = int'(mref[ra]);
                'hEA, 'hEE: begin
                    v = ((mv & 1) != 0) ? pre[1] : ((pre[1] + pre[2] + cy) & 15);
                    tr[0] = v;
                    mref[ra] = 4'(v);
                end
                default: ;
            endcase
            if ((st & 2) != 0) begin
                for (int j = 9; j > 0; j--) tr[j] = tr[j-1];
            end else begin
                pre[2] = pre[1];
                pre[1] = pre[0];
            end
            ps = st;
        end
        h  = 'h80 | (hosc >> 1);
        th = (tr[7] & 15) | ((tr[6] & 15) << 4) | ((tr[5] & 1) << 8);
        exp_row = ((tr[3] & 12) >> 2) | ((tr[2] & 15) << 2) | ((tr[1] & 7) << 6);
        exp_n = ((mv & 'h80) != 0) ? 0 : 256;
        for (int sx = 0; sx < 256; sx++) begin
            for (int k = 0; k < ((sx < 16) ? 2 : 4); k++) begin
                if (h > 255) begin
                    h  = ((tr[9] & 15) >> 1) | ((tr[8] & 15) << 3) | 'h80;
                    th = (th + 1) & 'hFFF;
                    if ((tr[9] & 1) != 0 && (th & 1) != 0) h = h - 1;
                end else begin
                    h = h + 1;
                end
            end
            exp_col[sx] = th & 'h1FF;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic start_line(input int ln, input int hz, input int bk);
        @(negedge clk);
        line_num   = 9'(ln);
        horizon    = 8'(hz);
        slope_bank = 2'(bk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic run_and_check(input int ln, input int hz, input int bk, input bit on);
        int base, n, bad_c, bad_r, fc_a, fc_e, fr_a;
        base = got_n;
        start_line(ln, hz, bk);
        repeat (LINE_WAIT) @(negedge clk);
        run_model(ln, hz, bk);
        n = got_n - base;
        chk(n == (on ? 256 : 0), "R7", "pixel count vs vector", n, on ? 256 : 0);
        chk(n == exp_n, "R1 R7", "pixel count vs model", n, exp_n);
        bad_c = 0; bad_r = 0; fc_a = 0; fc_e = 0; fr_a = 0;
        if (n == exp_n) begin
            for (int k = 0; k < n; k++) begin
                if (got_col[(base + k) & 255] != exp_col[k]) begin
                    if (bad_c == 0) begin fc_a = got_col[(base + k) & 255]; fc_e = exp_col[k]; end
                    bad_c++;
                end
                if (got_row[(base + k) & 255] != exp_row) begin
                    if (bad_r == 0) fr_a = got_row[(base + k) & 255];
                    bad_r++;
                end
            end
            if (n != 0) begin
                chk(bad_c == 0, "R3 R6 R8 R9", "tile column", fc_a, fc_e);
                chk(bad_r == 0, "R5 R10", "tile row", fr_a, exp_row);
            end
        end
        bad_c = 0; fc_a = 0; fc_e = 0;
        for (int a = 0; a < 64; a++) begin
            if (sram[a] != mref[a]) begin
                if (bad_c == 0) begin fc_a = int'(sram[a]); fc_e = int'(mref[a]); end
                bad_c++;
            end
        end
        chk(bad_c == 0, "R2 R4 R5 R6", "scratch RAM image", fc_a, fc_e);
    endtask

    initial begin
        int base;
        for (int a = 0; a < 64; a++) begin
            sram[a] = 4'((a * 7 + 3) & 15);
            mref[a] = 4'((a * 7 + 3) & 15);
        end
        do_reset();
        @(negedge clk);
        // R11: outputs quiet after reset
        chk(pix_valid == 1'b0, "R11", "pix_valid after reset", int'(pix_valid), 0);
        chk(ram_we == 1'b0, "R11", "ram_we after reset", int'(ram_we), 0);

        // vector table walk
        for (int i = 0; i < NVEC; i++) begin
            run_and_check(int'(VEC[i][19:11]), int'(VEC[i][10:3]), int'(VEC[i][2:1]), VEC[i][0]);
        end

        // R11: reset in the pixel phase stops output and restarts the line counter
        base = got_n;
        start_line(60, 0, 1);
        repeat (120) @(negedge clk);
        run_model(60, 0, 1);
        do_reset();
        mv = 0;
        for (int a = 0; a < 64; a++) mref[a] = sram[a];
        base = got_n;
        repeat (LINE_WAIT) @(negedge clk);
        chk(got_n == base, "R11", "pixels after mid-line reset", got_n - base, 0);
        chk(pix_valid == 1'b0, "R11", "pix_valid idle after reset", int'(pix_valid), 0);
        run_and_check(33, 0, 0, 1'b1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule